// File: doc/BRIEF.md
# Serialized Lane Reset Sequencer

This block sits between the soft reset controllers of the transceiver lanes on one side of a device and the lanes themselves. Every lane controller, whether it drives a transmitter lane or a receiver lane, raises its request line when it wants to enter or leave reset. The sequencer hands out permission to exactly one lane at a time, so no two lanes on the side change reset state together.

A grant is not a one-cycle arbitration pulse. It covers the whole multi-cycle reset transition of the chosen lane. The grant stays high until that lane raises its done line. After that, the grant falls and at least a configurable number of quiet cycles pass. Only then is the next lane chosen. The choice rotates: the search starts at the lane after the one served last, which keeps any lane from being starved. The request, done and grant lines are plain level-sensitive control pins. No data flows through the block, so it has no valid/ready interface and applies no back-pressure.

Top module: `lane_reset_sequencer`

## Requirements
- R1: At most one bit of `lane_grant_o` is high in any cycle.
- R2: When no grant is active and the quiet time has elapsed, the sequencer looks for a requesting lane. It searches upward from the rotation pointer and wraps from lane LANES-1 to lane 0. The first requesting lane it finds is granted one clock edge after that request is sampled.
- R3: Once a lane is granted, its grant bit stays high for as long as that lane's done bit is low. Changes on any request line do not alter it.
- R4: When the granted lane's done bit is sampled high, every grant bit is low after that clock edge. The rotation pointer then moves to the granted lane's index plus one, modulo LANES.
- R5: Between the end of one grant and the start of the next, every grant bit stays low for at least GAP_CYCLES cycles. The default is one cycle, and with that default a waiting request is granted on the edge after that cycle.
- R6: A request that falls before it is granted has no effect. It is not granted, and the rotation pointer does not move because of it.
- R7: While `rst_n` is low, all grant bits are low. The rotation pointer starts at lane 0, so the first grant after reset goes to the lowest requesting lane.
- R8: When every lane requests continuously, each lane is served exactly once in every LANES grants, in ascending circular order.
- R9: A done bit from a lane that holds no grant is ignored. So is any done bit while no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_req_i | input | LANES | Bit n high: lane n asks to change its reset state |
| lane_done_i | input | LANES | Bit n high: lane n has finished its transition |
| lane_grant_o | output | LANES | One-hot or zero; bit n high: lane n may change its reset state |

## Verification
Two things can land in the same cycle: a grant is released because of done, and a request appears or disappears. The bench provokes this by changing the done line and the request lines on the same falling edge. In one case a request appears in that cycle and drops during the quiet cycle. In another, the lane just served drops its request while a lane past the wrap asks. The outcome is judged by two checks: the grant must be zero for the quiet cycle, and the next grant must go to the first lane that is still requesting, counted from the advanced pointer.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic {
    LRS_IDLE = 1'b0,
    LRS_HOLD = 1'b1
  } lrs_state_e;
endpackage

// File: rtl/lrs_rr_pick.sv
// Circular search: first set request bit at or after the start index.
module lrs_rr_pick #(
  parameter int LANES = 8,
  parameter int IDX_W = 3
) (
  input  logic [LANES-1:0] req_i,
  input  logic [IDX_W-1:0] start_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W:0] cand;

  always_comb begin
    hit_o = 1'b0;
    idx_o = start_i;
    cand  = '0;
    for (int off = 0; off < LANES; off++) begin
      cand = {1'b0, start_i} + (IDX_W+1)'(off);
      if (cand >= (IDX_W+1)'(LANES)) cand = cand - (IDX_W+1)'(LANES);
      if (!hit_o && req_i[cand[IDX_W-1:0]]) begin
        hit_o = 1'b1;
        idx_o = cand[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/lrs_gap_timer.sv
// Counts the quiet cycles after a grant is released.
module lrs_gap_timer #(
  parameter int GAP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic quiet_o
);
  localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= CNT_W'(GAP_CYCLES - 1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign quiet_o = (cnt_q == '0);
endmodule

// File: rtl/lrs_grant_ctrl.sv
// Holds the owner lane until it reports done; advances the rotation pointer.
module lrs_grant_ctrl
  import lrs_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] done_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] pick_i,
  input  logic             quiet_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             release_o,
  output logic [LANES-1:0] grant_o
);
  lrs_state_e       state_q;
  logic [IDX_W-1:0] owner_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] owner_next;

  assign release_o = (state_q == LRS_HOLD) && done_i[owner_q];
  assign owner_next = (owner_q == IDX_W'(LANES - 1)) ? '0 : owner_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LRS_IDLE;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        LRS_IDLE: if (quiet_i && hit_i) begin
          state_q <= LRS_HOLD;
          owner_q <= pick_i;
        end
        LRS_HOLD: if (release_o) begin
          state_q <= LRS_IDLE;
          ptr_q   <= owner_next;
        end
        default: state_q <= LRS_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_grant
    assign grant_o[g] = (state_q == LRS_HOLD) && (owner_q == IDX_W'(g));
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/lane_reset_sequencer.sv
module lane_reset_sequencer #(
  parameter int LANES      = 8,
  parameter int GAP_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_req_i,
  input  logic [LANES-1:0] lane_done_i,
  output logic [LANES-1:0] lane_grant_o
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic             hit;
  logic [IDX_W-1:0] pick;
  logic [IDX_W-1:0] ptr;
  logic             quiet;
  logic             release_pulse;

  lrs_rr_pick #(.LANES(LANES), .IDX_W(IDX_W)) u_pick (
    .req_i   (lane_req_i),
    .start_i (ptr),
    .hit_o   (hit),
    .idx_o   (pick)
  );

  lrs_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (release_pulse),
    .quiet_o (quiet)
  );

  lrs_grant_ctrl #(.LANES(LANES), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (lane_done_i),
    .hit_i     (hit),
    .pick_i    (pick),
    .quiet_i   (quiet),
    .ptr_o     (ptr),
    .release_o (release_pulse),
    .grant_o   (lane_grant_o)
  );
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] req,
  input logic [LANES-1:0] done,
  input logic [LANES-1:0] grant
);
  // R1
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2, R6: a new grant goes only to a lane that was requesting
  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && $past(grant) == '0) |-> (($past(req) & grant) != '0));

  // R3, R9: held while owner not done
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (grant & done) == '0) |=> (grant == $past(grant)));

  // R4, R5: owner done -> all grants low next cycle
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & done) != '0) |=> (grant == '0));

  // R7
  a_r7_reset_quiet: assert property (@(posedge clk)
    (!rst_n) |-> (grant == '0));
endmodule

bind lane_reset_sequencer lrs_checker #(.LANES(LANES)) u_lrs_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (lane_req_i),
  .done  (lane_done_i),
  .grant (lane_grant_o)
);

// File: tb/lane_reset_sequencer_tb.sv
module lane_reset_sequencer_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] done;
  logic [N-1:0] grant;
  int           n_chk = 0;
  int           n_bad = 0;

  always #5 clk = ~clk;

  lane_reset_sequencer #(.LANES(N), .GAP_CYCLES(1)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lane_req_i   (req),
    .lane_done_i  (done),
    .lane_grant_o (grant)
  );

  function automatic logic [N-1:0] bit_of(input int lane);
    return N'(1) << lane;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] exp);
    n_chk++;
    if (grant !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = '0; done = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R7 grant low in reset", '0);
    rst_n = 1'b1;
    done = '1;
    @(negedge clk); chk("R9 done with no grant", '0);
    done = '0;
  endtask

  task automatic t_single();
    req = bit_of(3);
    @(negedge clk); chk("R2 lane3 granted", bit_of(3));
    req = '0; done = bit_of(5);
    @(negedge clk); chk("R3 R9 hold despite req drop and foreign done", bit_of(3));
    done = '0; req = bit_of(2);
    @(negedge clk); chk("R3 hold despite other request", bit_of(3));
    done = bit_of(3);
    @(negedge clk); chk("R4 release after done", '0);
    done = '0;
    @(negedge clk); chk("R5 grant after one quiet cycle", bit_of(2));
    done = bit_of(2); req = '0;
    @(negedge clk); chk("R4 release lane2", '0);
    done = '0;
  endtask

  task automatic t_pointer();
    req = bit_of(1) | bit_of(6);
    @(negedge clk); chk("R4 pointer at 3 picks lane6", bit_of(6));
    done = bit_of(6); req = bit_of(1);
    @(negedge clk); chk("R5 quiet cycle", '0);
    done = '0;
    @(negedge clk); chk("R2 wrap to lane1", bit_of(1));
    done = bit_of(1); req = '0;
    @(negedge clk); chk("R4 release lane1", '0);
    done = '0;
  endtask

  task automatic t_withdraw();
    req = bit_of(7);
    @(negedge clk); chk("R2 pointer 2 picks lane7", bit_of(7));
    done = bit_of(7); req = bit_of(1);
    @(negedge clk); chk("R4 release lane7", '0);
    done = '0; req = bit_of(5);
    @(negedge clk); chk("R6 withdrawn lane1 ignored", bit_of(5));
    done = bit_of(5); req = '0;
    @(negedge clk); chk("R4 release lane5", '0);
    done = '0;
  endtask

  task automatic t_all();
    req = '1;
    for (int k = 0; k < N; k++) begin
      int lane;
      lane = (6 + k) % N;
      @(negedge clk); chk("R8 rotation order", bit_of(lane));
      done = bit_of(lane);
      @(negedge clk); chk("R5 quiet between rotations", '0);
      done = '0;
    end
  endtask

  task automatic t_reset_mid();
    @(negedge clk); chk("R8 rotation restarts at lane6", bit_of(6));
    rst_n = 1'b0;
    @(negedge clk); chk("R7 reset clears grant", '0);
    rst_n = 1'b1;
    @(negedge clk); chk("R7 pointer back at lane0", bit_of(0));
    done = bit_of(0); req = '0;
    @(negedge clk); chk("R4 release lane0", '0);
    done = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_pointer();
    t_withdraw();
    t_all();
    t_reset_mid();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule